// File: doc/BRIEF.md
# Slave-Side Serial Audio Codec Framer

This block is the slave end of a serial audio codec link. An external master supplies the bit clock and the frame-sync line. The block samples both with its own system clock. When it sees a valid sync event, it shifts one complete frame of words out on the serial data output and captures the matching words from the serial data input. Words enter and leave through parallel ports that each use a valid/ready handshake.

Three framing schemes are selected by `mode`:

- **Multi-channel (`00`, and `11`):** a frame starts on a sync pulse sampled high.
- **I2S-style (`01`):** any change of level on the sync line starts a frame.
- **AC-link-style (`10`):** a sync sampled high starts a 256-bit frame. The frame is one 16-bit tag slot followed by twelve 20-bit slots.

In the two non-AC modes the frame is `frame_words` words of `word_bits` bits each. Both fields must match the external master. While a frame is in progress, further sync events are ignored. The only exception is a sync on the rising edge that carries the frame's final bit, which allows back-to-back frames.

Top module: `codec_slave_framer`

## Requirements
- R1: In multi-channel mode (`mode` = 00, and also 11), a bit-clock rising edge with `fsync` high, while idle, starts a frame. The first bit appears on `sdo` after the next bit-clock falling edge, and `sdi` is captured on each rising edge after that.
- R2: In I2S-style mode (`mode` = 01), a frame starts when the level of `fsync` sampled on a bit-clock rising edge differs from the level sampled on the previous rising edge. Either direction counts as a sync.
- R3: In AC-link-style mode (`mode` = 10), a frame is slot 0 of 16 bits, which carries the low 16 bits of its transmit word, followed by 12 slots of 20 bits each.
- R4: In modes 00, 01 and 11, a frame lasts `word_bits` × `frame_words` bit-clock cycles. Sync events inside a frame are ignored, except on the rising edge that captures the frame's final bit, where a sync chains a new frame with no idle gap.
- R5: Each word is sent most-significant bit first, starting at bit `slot length − 1`. `sdo` changes only after a bit-clock falling edge and is 0 while no frame is running.
- R6: Transmit words are taken into a single holding register. `tx_ready` is low while that register is full, and the register empties when a slot begins.
- R7: If a slot begins with no transmit word held, all of its bits are sent as 0 and `underflow` is set. `underflow` stays set until reset.
- R8: Each received slot is presented on `rx_data`, right-aligned with the upper bits zero, together with `rx_valid`. `rx_valid` stays high until a cycle with `rx_ready` high.
- R9: If a received slot completes while the previous one is still unaccepted, `overflow` is set and stays set until reset, and the newer word replaces the older one on `rx_data`.
- R10: After reset, `sdo`, `rx_valid`, `underflow` and `overflow` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Framing scheme: 00 multi-channel, 01 I2S-style, 10 AC-link-style, 11 as 00 |
| word_bits | input | 5 | Bits per word in modes 00, 01 and 11 (4 to 16) |
| frame_words | input | 5 | Words per frame in modes 00, 01 and 11 (1 to 16) |
| bclk | input | 1 | Bit clock from the external master |
| fsync | input | 1 | Frame-sync line from the external master |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| tx_data | input | 20 | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register can take a word |
| rx_data | output | 20 | Received word, right-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| underflow | output | 1 | Sticky: a slot started with no transmit word |
| overflow | output | 1 | Sticky: a received word was overwritten |

## Verification
Multi-channel frames are run with several word sizes and word counts. This shows that the slot length and the frame length both follow the configuration, rather than a fixed width. A stray sync pulse in mid-frame, and a sync on the final bit, show that mid-frame syncs are ignored while the final bit chains the next frame. I2S-style frames are started once by a rising and once by a falling level change, which shows that both polarities work. A full AC-link-style frame shows that the tag is cut to 16 bits while the later slots carry 20. Finally, a frame with no transmit words and a frame with the receive side stalled produce zero data and the two sticky flags.

// File: rtl/codec_slave_framer.sv
module codec_slave_framer #(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int AC_SLOTS  = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic [4:0]           word_bits,
  input  logic [4:0]           frame_words,
  input  logic                 bclk,
  input  logic                 fsync,
  input  logic                 sdi,
  output logic                 sdo,
  input  logic [SLOT_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [SLOT_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 underflow,
  output logic                 overflow
);
  localparam int W  = SLOT_BITS;
  localparam int CW = $clog2(W + 1);

  logic b0, b1, b2, fs0, fs1, sd0, sd1, fs_last;
  logic active, pend, load_req, hold_full;
  logic [4:0]    slot;
  logic [CW-1:0] bidx;
  logic [W-1:0]  txsh, hold, rxsh;

  wire rise   = b1 & ~b2;
  wire fall   = ~b1 & b2;
  wire is_i2s = (mode == 2'b01);
  wire is_ac  = (mode == 2'b10);

  wire sync_ev   = is_i2s ? (fs1 ^ fs_last) : fs1;
  wire last_slot = is_ac ? (slot == 5'(AC_SLOTS - 1)) : (slot == frame_words - 5'd1);
  wire frame_end = active && (bidx == '0) && last_slot;

  wire [CW-1:0] slot_len = is_ac ? ((slot == 5'd0) ? CW'(TAG_BITS) : CW'(SLOT_BITS))
                                 : CW'(word_bits);
  wire [CW-1:0] top      = slot_len - CW'(1);
  wire [W-1:0]  nxt      = hold_full ? hold : '0;
  wire          load_now = fall && (pend || (active && load_req));
  wire [W-1:0]  rx_word  = {rxsh[W-2:0], sd1};

  assign tx_ready = ~hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {b0, b1, b2, fs0, fs1, sd0, sd1, fs_last} <= '0;
      {active, pend, load_req, hold_full} <= '0;
      slot <= '0;
      bidx <= '0;
      txsh <= '0;
      hold <= '0;
      rxsh <= '0;
      sdo <= 1'b0;
      rx_data <= '0;
      rx_valid <= 1'b0;
      underflow <= 1'b0;
      overflow <= 1'b0;
    end else begin
      b0 <= bclk;  b1 <= b0;  b2 <= b1;
      fs0 <= fsync; fs1 <= fs0;
      sd0 <= sdi;  sd1 <= sd0;

      if (tx_valid && !hold_full) begin
        hold <= tx_data;
        hold_full <= 1'b1;
      end
      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      if (rise) begin
        fs_last <= fs1;
        if (active) begin
          if (bidx == '0) begin
            rx_data  <= rx_word;
            rx_valid <= 1'b1;
            rxsh     <= '0;
            if (rx_valid && !rx_ready) overflow <= 1'b1;
            if (last_slot) active <= 1'b0;
            else begin
              slot     <= slot + 5'd1;
              load_req <= 1'b1;
            end
          end else begin
            rxsh <= rx_word;
            bidx <= bidx - CW'(1);
          end
        end
        if (sync_ev && ((!active && !pend) || frame_end)) begin
          pend <= 1'b1;
          slot <= '0;
        end
      end

      if (fall) begin
        if (load_now) begin
          txsh     <= nxt;
          bidx     <= top;
          sdo      <= nxt[top];
          load_req <= 1'b0;
          if (hold_full) hold_full <= 1'b0;
          else underflow <= 1'b1;
          if (pend) begin
            active <= 1'b1;
            pend   <= 1'b0;
          end
        end else if (active) sdo <= txsh[bidx];
        else sdo <= 1'b0;
      end
    end
  end

  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);
  // R6
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R5
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo));
endmodule

// File: tb/sim_codec_slave_framer.sv
module sim_codec_slave_framer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [4:0] word_bits = 5'd8, frame_words = 5'd1;
  logic bclk = 1'b1, fsync = 1'b0, sdi = 1'b0, sdo;
  logic [19:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b1, underflow, overflow;

  codec_slave_framer u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .word_bits(word_bits),
    .frame_words(frame_words), .bclk(bclk), .fsync(fsync), .sdi(sdi), .sdo(sdo),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .underflow(underflow), .overflow(overflow));

  int checks = 0, fails = 0;
  bit exp_bits[$];
  logic [19:0] rx_q[$], tx_q[$];
  logic [19:0] last_rw[16];
  bit rx_mon_en = 1'b1;
  logic fs_lvl = 1'b0;
  int unsigned lcg = 32'h1234_5678;
  string cur_req = "R1";
  event smp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] next_word();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[27:8];
  endfunction

  initial forever begin
    @(smp);
    if (exp_bits.size() > 0) begin
      bit e;
      e = exp_bits.pop_front();
      chk(sdo === e, cur_req, int'(sdo), int'(e));
    end else chk(sdo === 1'b0, "R5 idle", int'(sdo), 0);
  end

  always @(negedge clk) begin
    if (rx_mon_en && rx_valid && rx_ready) begin
      if (rx_q.size() > 0) begin
        logic [19:0] e;
        e = rx_q.pop_front();
        chk(rx_data === e, cur_req, int'(rx_data), int'(e));
      end else chk(1'b0, "R8 unexpected word", int'(rx_data), 0);
    end
  end

  always @(negedge clk) begin
    if (!tx_valid && tx_ready && rst_n && tx_q.size() > 0) begin
      tx_data  = tx_q.pop_front();
      tx_valid = 1'b1;
    end else tx_valid = 1'b0;
  end

  task automatic bclk_cycle(input logic fs, input logic sd);
    bclk = 1'b0; fsync = fs; sdi = sd;
    repeat (4) @(negedge clk);
    ->smp;
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input int wb, input int nw);
    @(negedge clk);
    mode = m; word_bits = 5'(wb); frame_words = 5'(nw);
  endtask

  task automatic do_frame(input bit give_tx, input bit chained, input bit end_sync,
                          input int noise_at, input string req);
    int nslots, n;
    int lens[16];
    logic [19:0] tw[16];
    logic [19:0] rw[16];
    nslots = (mode == 2'b10) ? 13 : int'(frame_words);
    cur_req = req;
    for (int i = 0; i < nslots; i++) begin
      lens[i] = (mode == 2'b10) ? ((i == 0) ? 16 : 20) : int'(word_bits);
      tw[i] = next_word();
      rw[i] = next_word() & ((20'd1 << lens[i]) - 20'd1);
      last_rw[i] = rw[i];
      if (give_tx) tx_q.push_back(tw[i]);
    end
    if (!chained) begin
      repeat (20) @(negedge clk);
      if (give_tx) chk(tx_ready === 1'b0, "R6 holding full", int'(tx_ready), 0);
      if (mode == 2'b01) begin
        fs_lvl = ~fs_lvl;
        bclk_cycle(fs_lvl, 1'b0);
      end else bclk_cycle(1'b1, 1'b0);
    end
    for (int i = 0; i < nslots; i++) begin
      for (int b = lens[i] - 1; b >= 0; b--) exp_bits.push_back(give_tx ? tw[i][b] : 1'b0);
      if (rx_mon_en) rx_q.push_back(rw[i]);
    end
    n = 0;
    for (int i = 0; i < nslots; i++) begin
      for (int b = lens[i] - 1; b >= 0; b--) begin
        logic f;
        f = (mode == 2'b01) ? fs_lvl : 1'b0;
        if (n == noise_at) f = 1'b1;
        if (end_sync && i == nslots - 1 && b == 0) begin
          if (mode == 2'b01) begin
            fs_lvl = ~fs_lvl;
            f = fs_lvl;
          end else f = 1'b1;
        end
        bclk_cycle(f, rw[i][b]);
        n++;
      end
    end
  endtask

  task automatic reset_check();
    chk(sdo === 1'b0, "R10 sdo", int'(sdo), 0);
    chk(rx_valid === 1'b0, "R10 rx_valid", int'(rx_valid), 0);
    chk(underflow === 1'b0, "R10 underflow", int'(underflow), 0);
    chk(overflow === 1'b0, "R10 overflow", int'(overflow), 0);
    chk(tx_ready === 1'b1, "R10 tx_ready", int'(tx_ready), 1);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    set_cfg(2'b00, 8, 2);
    do_frame(1'b1, 1'b0, 1'b0, -1, "R1 multi-channel frame");
    set_cfg(2'b00, 16, 3);
    do_frame(1'b1, 1'b0, 1'b0, 10, "R4 mid-frame sync ignored");
    set_cfg(2'b00, 5, 1);
    do_frame(1'b1, 1'b0, 1'b1, -1, "R4 chain first");
    do_frame(1'b1, 1'b1, 1'b0, -1, "R4 chain second");
    set_cfg(2'b11, 6, 2);
    do_frame(1'b1, 1'b0, 1'b0, -1, "R1 mode 11 as multi-channel");

    fs_lvl = 1'b0;
    set_cfg(2'b01, 16, 1);
    do_frame(1'b1, 1'b0, 1'b1, -1, "R2 rising-edge sync");
    do_frame(1'b1, 1'b1, 1'b0, -1, "R2 falling-edge sync");
    set_cfg(2'b01, 12, 2);
    do_frame(1'b1, 1'b0, 1'b0, -1, "R2 rising-edge sync 12-bit");

    set_cfg(2'b10, 8, 1);
    do_frame(1'b1, 1'b0, 1'b0, -1, "R3 tag and slots");

    bclk_cycle(1'b0, 1'b0);
    chk(underflow === 1'b0, "R7 no underflow yet", int'(underflow), 0);
    chk(overflow === 1'b0, "R9 no overflow yet", int'(overflow), 0);

    set_cfg(2'b00, 4, 1);
    do_frame(1'b0, 1'b0, 1'b0, -1, "R7 zeros on underflow");
    @(negedge clk);
    chk(underflow === 1'b1, "R7 underflow set", int'(underflow), 1);

    rx_ready = 1'b0;
    rx_mon_en = 1'b0;
    set_cfg(2'b00, 4, 2);
    do_frame(1'b1, 1'b0, 1'b0, -1, "R9 overflow frame");
    repeat (8) @(negedge clk);
    chk(overflow === 1'b1, "R9 overflow set", int'(overflow), 1);
    chk(rx_valid === 1'b1, "R8 word held", int'(rx_valid), 1);
    chk(rx_data === last_rw[1], "R9 newer word kept", int'(rx_data), int'(last_rw[1]));
    rx_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rx_valid === 1'b0, "R8 taken", int'(rx_valid), 0);
    rx_mon_en = 1'b1;
    bclk_cycle(1'b0, 1'b0);
    chk(underflow === 1'b1, "R7 still set", int'(underflow), 1);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule